// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Unit

This unit answers a cache line refill of four words from a main memory built as four word-interleaved banks. Word k of every block sits in bank k, at a row equal to the block address. A request carries the block address. The unit spends one cycle presenting that address, waits out the bank read latency, and then hands the four words back in ascending offset order. Each returned word carries a valid strobe and its 2-bit offset. A done pulse marks the last word.

Two modes are offered, chosen per request. In interleaved mode all four banks read at the same time and the words stream out on four consecutive cycles, so a refill takes 1 + 15 + 4 = 20 cycles. In sequential mode the banks are read one after another: a single address cycle is followed by four rounds of a 15-cycle read plus one transfer cycle, so a refill takes 65 cycles. A plain single-word write port fills the banks. The low two bits of the word address choose the bank and the remaining bits choose the row.

Top module: `ilv_refill`

## Requirements
- R1: After reset, busy, word_vld and done are all low.
- R2: The write port stores wr_data in bank wr_addr[1:0] at row wr_addr[AW+1:2]. A refill of block address A returns, at offset k, the word last written to bank k, row A.
- R3: In interleaved mode (ilv_mode=1 when the request is accepted), with the request sampled at clock edge E, offset k is presented in the cycle after edge E+16+k, for k = 0..3.
- R4: Within a refill, words are presented in order of offsets 0, 1, 2, 3. word_vld is high only in those four cycles, and word_off shows the offset.
- R5: In sequential mode (ilv_mode=0 when the request is accepted), offset k is presented in the cycle after edge E+16+16k, and word_vld is low in every cycle between words.
- R6: done is high for exactly one cycle, the cycle that presents offset 3. busy is high from the cycle after E through that cycle and low in the next, which gives 20 busy cycles in interleaved mode and 65 in sequential mode.
- R7: A request raised while busy is high is ignored. It does not change the words or timing of the refill in progress, and it starts no refill afterwards.
- R8: ilv_mode is sampled only when a request is accepted. Changing it during a refill has no effect on that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ilv_mode | input | 1 | 1 = parallel bank read, 0 = one bank at a time |
| req | input | 1 | Refill request, accepted only while idle |
| req_addr | input | AW | Block address |
| wr_en | input | 1 | Single-word bank write |
| wr_addr | input | AW+2 | Word address for the write |
| wr_data | input | DW | Write data |
| busy | output | 1 | Refill in progress |
| word_vld | output | 1 | A returned word is present |
| word_off | output | 2 | Offset of the returned word |
| word_data | output | DW | Returned word |
| done | output | 1 | Last word of the block |

## Verification
The request is raised just after a falling edge, so the edge that accepts it is the next rising edge, E. From E onward the bench counts rising edges and samples every output at the falling edge that follows. In that cycle it compares busy, word_vld, word_off, word_data and done against a schedule derived from the requirements. Offset k is due at count 16+k in interleaved mode and at count 16+16k in sequential mode. The last word is at count 19 or 64, and busy must be low from the count after it. Every cycle is checked, including the gaps between words and three cycles past the end. This makes an early word, a late word, an extra strobe or a restart from a request made while busy a mismatch on a specific cycle.

// File: rtl/ilv_refill.sv
module ilv_refill #(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int LAT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ilv_mode,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          wr_en,
  input  logic [AW+1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          word_vld,
  output logic [1:0]    word_off,
  output logic [DW-1:0] word_data,
  output logic          done
);
  localparam int NB    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_XFER} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    idx;
  logic [AW-1:0] blk_q;
  logic          ilv_q;
  logic          fire;
  logic [DW-1:0] bank_q [NB];

  assign fire = (st == S_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      blk_q <= '0;
      ilv_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st    <= S_SEND;
          blk_q <= req_addr;
          ilv_q <= ilv_mode;
          idx   <= '0;
        end
        S_SEND: begin
          st  <= S_WAIT;
          cnt <= CW'(LAT - 1);
        end
        S_WAIT: begin
          if (fire) st <= S_XFER;
          else      cnt <= cnt - 1'b1;
        end
        S_XFER: begin
          if (idx == 2'd3) begin
            st <= S_IDLE;
          end else begin
            idx <= idx + 2'd1;
            if (!ilv_q) begin
              st  <= S_WAIT;
              cnt <= CW'(LAT - 1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr[1:0] == 2'(b)) mem[wr_addr[AW+1:2]] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (fire && (ilv_q || idx == 2'(b)))    q <= mem[blk_q];
    end
    assign bank_q[b] = q;
  end

  assign busy      = (st != S_IDLE);
  assign word_vld  = (st == S_XFER);
  assign word_off  = idx;
  assign word_data = bank_q[idx];
  assign done      = word_vld && (idx == 2'd3);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !word_vld);
  // R4
  ilv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && ilv_q && word_off != 2'd3) |=> (word_vld && word_off == $past(word_off) + 2'd1));
  // R5
  seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !ilv_q && word_off != 2'd3) |=> !word_vld);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(blk_q)));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(ilv_q)));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (cnt < CW'(LAT)));
endmodule

// File: tb/sim_ilv_refill.sv
`timescale 1ns/1ps
module sim_ilv_refill;
  localparam int DW = 32, AW = 8, LAT = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ilv_mode = 1'b0, req = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW+1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy, word_vld, done;
  logic [1:0] word_off;
  logic [DW-1:0] word_data;
  logic [DW-1:0] shadow [4][256];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ilv_refill #(.DW(DW), .AW(AW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode), .req(req), .req_addr(req_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .word_vld(word_vld), .word_off(word_off), .word_data(word_data), .done(done));

  function automatic logic [DW-1:0] pat(input int row, input int bk);
    return 32'hB000_0000 + (bk << 20) + row * 32'h0000_0101;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bank_write(input int row, input int bk, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = (AW+2)'(row * 4 + bk); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[bk][row] = d;
  endtask

  // One full refill, checked cycle by cycle (R3..R8); poke adds a busy-time request and a mode flip.
  task automatic refill(input int addr, input logic mode, input bit poke, input string tag);
    int step, last;
    step = mode ? 1 : LAT + 1;
    last = LAT + 1 + 3 * step;
    @(negedge clk);
    ilv_mode = mode; req = 1'b1; req_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int n = 0; n <= last + 3; n++) begin
      logic ev; int k;
      if (n > 0) begin @(posedge clk); @(negedge clk); end
      k = (n - LAT - 1) / step;
      ev = (n >= LAT + 1) && ((n - LAT - 1) % step == 0) && (k <= 3);
      chk({tag, " busy"}, 64'(busy), 64'(n <= last));
      chk({tag, " vld"}, 64'(word_vld), 64'(ev));
      chk({tag, " R6 done"}, 64'(done), 64'(ev && k == 3));
      if (ev) begin
        chk({tag, " R4 off"}, 64'(word_off), 64'(k));
        chk({tag, " R2 data"}, 64'(word_data), 64'(shadow[k][addr]));
      end
      if (poke && n == 3) ilv_mode = ~mode;
      if (poke && n == 5) begin req = 1'b1; req_addr = AW'(addr ^ 1); end
      if (poke && n == 6) req = 1'b0;
      if (poke && n == last) begin req = 1'b1; req_addr = AW'(addr ^ 2); end
      if (poke && n == last + 1) req = 1'b0;
    end
    ilv_mode = mode;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 vld", 64'(word_vld), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++) bank_write(r, b, pat(r, b));
    for (int b = 0; b < 4; b++) bank_write(255, b, pat(255, b));
    refill(2, 1'b1, 1'b0, "R3 ilv");
    refill(255, 1'b1, 1'b0, "R3 ilv top");
    refill(1, 1'b0, 1'b0, "R5 seq");
    refill(3, 1'b1, 1'b1, "R7 R8 ilv poke");
    refill(0, 1'b0, 1'b1, "R7 R8 seq poke");
    bank_write(2, 2, 32'hDEAD_2222);
    refill(2, 1'b1, 1'b0, "R2 rewrite");
    t_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule